// File: doc/BRIEF.md
# Emulator Mode State Controller

This block keeps the processor's emulator (debug) mode flag correct as exceptions are taken and returned from. A debug interrupt always enters emulator mode. An ordinary exception that starts during a debug service routine writes the live flag into the fault-status bit of the new stack frame and then clears the flag, so that the handler runs as normal code. When the handler returns, the bit reloaded from the frame decides whether emulator mode comes back. If it does, the processor status output again shows the debug-entry code. Each nesting level keeps its own copy of the bit in its own frame, so the block holds no internal stack.

After every exception return, breakpoint-triggered debug interrupt requests are masked until the first instruction after the return completes. A request that arrives inside that window is dropped, not queued. At reset, a force-emulation control bit is sampled only at the moment reset exception processing begins. It may be written freely while the core is halted before that moment. Stack memory, the trigger comparators and the debug command port sit outside the block and connect through plain ports.

Top module: `emu_mode_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it drops, `emu_mode`, `bkpt_inhibit`, `bkpt_fire` and `frame_we` are 0, `pst` is 4'h0 and `frame_word` is all zeros.
- R2: An `exc_start` with `exc_is_debug`=1 sets `emu_mode` in the next cycle, and `pst` shows 4'hD for exactly that one cycle.
- R3: An `exc_start` with `exc_is_debug`=0 pulses `frame_we` for one cycle. On that cycle `frame_word` carries the previous `emu_mode` at bit 17 and zeros in every other bit, and `emu_mode` reads 0.
- R4: An `rte_done` with `rte_fs1`=1 sets `emu_mode` in the next cycle, and `pst` shows 4'hD for exactly that one cycle.
- R5: An `rte_done` with `rte_fs1`=0 leaves `emu_mode` at 0 in the next cycle, and `pst` reads 4'h0.
- R6: `bkpt_inhibit` rises in the cycle after an accepted `rte_done`. It falls in the cycle after the first `instr_done` sampled while it is high. A `bkpt_req` in the return cycle or in any inhibited cycle gives no `bkpt_fire`. Any other `bkpt_req` gives a one-cycle `bkpt_fire` in the following cycle.
- R7: A `rst_exc_start` loads `emu_mode` with the value of `force_emu` in the next cycle.
- R8: `force_emu` has no effect on `emu_mode` in any cycle without `rst_exc_start`.
- R9: Ordinary exceptions nested two deep inside a debug routine write 1 and then 0 as the saved bit, and the matching returns restore 0 and then 1.
- R10: When several events coincide, `rst_exc_start` wins over `exc_start`, which wins over `rte_done`. A losing return neither changes the mode nor starts the inhibit window.
- R11: `emu_mode` holds its value in any cycle with no `rst_exc_start`, `exc_start` or `rte_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_start | input | 1 | Exception processing begins (pulse) |
| exc_is_debug | input | 1 | The starting exception is a debug interrupt |
| rte_done | input | 1 | An exception return reloads its frame (pulse) |
| rte_fs1 | input | 1 | Fault-status bit read back from the frame |
| rst_exc_start | input | 1 | Reset is negated and reset exception processing begins |
| force_emu | input | 1 | Force-emulation control bit |
| instr_done | input | 1 | One instruction completed (strobe) |
| bkpt_req | input | 1 | Breakpoint trigger asks for a debug interrupt |
| emu_mode | output | 1 | Current emulator mode flag |
| frame_word | output | 32 | Stack-frame word carrying the saved bit at bit 17 |
| frame_we | output | 1 | Write strobe for `frame_word` |
| pst | output | 4 | Processor status code (4'hD debug entry, 4'h0 otherwise) |
| bkpt_inhibit | output | 1 | Breakpoint masking window after a return is active |
| bkpt_fire | output | 1 | Breakpoint request passed on as a debug interrupt |

## Verification
The bound checker tests the rules that fit one or two clock cycles on every cycle: debug entry sets the flag, an ordinary exception saves and clears it, a return restores it with the matching status code, the force bit matters only at reset-exception start, the flag holds between events, and requests are blocked while the inhibit is high. The bench scenarios cover what spans longer histories. These are the two-deep nesting in which each frame carries its own bit, the length of the inhibit window up to the first completed instruction, the dropping rather than queueing of masked requests, and same-cycle collisions between events. A behavioural model of all outputs is compared on every clock through each scenario.

// File: rtl/emu_pkg.sv
package emu_pkg;
  localparam int PST_W = 4;
  localparam logic [PST_W-1:0] PST_NORMAL = 4'h0;
  localparam logic [PST_W-1:0] PST_DEBUG  = 4'hD;

  // one event accepted per cycle, after priority resolution
  typedef enum logic [1:0] {
    EV_NONE      = 2'd0,
    EV_RST_START = 2'd1,
    EV_EXC       = 2'd2,
    EV_RET       = 2'd3
  } emu_ev_e;
endpackage

// File: rtl/emu_state_reg.sv
module emu_state_reg
  import emu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  emu_ev_e          ev,
  input  logic             is_debug,
  input  logic             ret_bit,
  input  logic             force_bit,
  output logic             mode_q,
  output logic [PST_W-1:0] pst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      pst_q  <= PST_NORMAL;
    end else begin
      pst_q <= PST_NORMAL;
      case (ev)
        EV_RST_START: mode_q <= force_bit;
        EV_EXC: begin
          if (is_debug) begin
            mode_q <= 1'b1;
            pst_q  <= PST_DEBUG;
          end else begin
            mode_q <= 1'b0;
          end
        end
        EV_RET: begin
          mode_q <= ret_bit;
          if (ret_bit) pst_q <= PST_DEBUG;
        end
        default: mode_q <= mode_q;
      endcase
    end
  end
endmodule

// File: rtl/emu_frame_pack.sv
module emu_frame_pack #(
  parameter int WORD_W  = 32,
  parameter int FS1_POS = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              save_en,
  input  logic              save_bit,
  output logic [WORD_W-1:0] word_q,
  output logic              we_q
);
  localparam logic [WORD_W-1:0] FS1_MASK = {{(WORD_W-1){1'b0}}, 1'b1} << FS1_POS;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      we_q   <= 1'b0;
    end else begin
      we_q <= save_en;
      if (save_en) word_q <= save_bit ? FS1_MASK : '0;
    end
  end
endmodule

// File: rtl/emu_bkpt_gate.sv
module emu_bkpt_gate (
  input  logic clk,
  input  logic rst,
  input  logic ret_accept,
  input  logic ret_raw,
  input  logic instr_done,
  input  logic req,
  output logic inhibit_q,
  output logic fire_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inhibit_q <= 1'b0;
      fire_q    <= 1'b0;
    end else begin
      // the return cycle itself and every inhibited cycle drop the request
      fire_q <= req & ~ret_raw & ~inhibit_q;
      if (ret_accept)      inhibit_q <= 1'b1;
      else if (instr_done) inhibit_q <= 1'b0;
    end
  end
endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
  import emu_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int FS1_POS = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_start,
  input  logic              exc_is_debug,
  input  logic              rte_done,
  input  logic              rte_fs1,
  input  logic              rst_exc_start,
  input  logic              force_emu,
  input  logic              instr_done,
  input  logic              bkpt_req,
  output logic              emu_mode,
  output logic [WORD_W-1:0] frame_word,
  output logic              frame_we,
  output logic [PST_W-1:0]  pst,
  output logic              bkpt_inhibit,
  output logic              bkpt_fire
);
  emu_ev_e ev;

  always_comb begin
    if (rst_exc_start)  ev = EV_RST_START;
    else if (exc_start) ev = EV_EXC;
    else if (rte_done)  ev = EV_RET;
    else                ev = EV_NONE;
  end

  emu_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .is_debug  (exc_is_debug),
    .ret_bit   (rte_fs1),
    .force_bit (force_emu),
    .mode_q    (emu_mode),
    .pst_q     (pst)
  );

  emu_frame_pack #(.WORD_W(WORD_W), .FS1_POS(FS1_POS)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .save_en  (ev == EV_EXC),
    .save_bit (emu_mode),
    .word_q   (frame_word),
    .we_q     (frame_we)
  );

  emu_bkpt_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .ret_accept (ev == EV_RET),
    .ret_raw    (rte_done),
    .instr_done (instr_done),
    .req        (bkpt_req),
    .inhibit_q  (bkpt_inhibit),
    .fire_q     (bkpt_fire)
  );
endmodule

// File: rtl/emu_mode_ctrl_chk.sv
module emu_mode_ctrl_chk #(
  parameter int WORD_W  = 32,
  parameter int FS1_POS = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_start,
  input logic              exc_is_debug,
  input logic              rte_done,
  input logic              rte_fs1,
  input logic              rst_exc_start,
  input logic              force_emu,
  input logic              bkpt_req,
  input logic              emu_mode,
  input logic [WORD_W-1:0] frame_word,
  input logic              frame_we,
  input logic [3:0]        pst,
  input logic              bkpt_inhibit,
  input logic              bkpt_fire
);
  AST_DEBUG_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (exc_start && exc_is_debug && !rst_exc_start) |=> (emu_mode && pst == 4'hD)); // R2

  AST_ORDINARY_SAVE: assert property (@(posedge clk) disable iff (rst)
    (exc_start && !exc_is_debug && !rst_exc_start) |=>
      (!emu_mode && frame_we && frame_word[FS1_POS] == $past(emu_mode))); // R3

  AST_RET_REENTER: assert property (@(posedge clk) disable iff (rst)
    (rte_done && rte_fs1 && !exc_start && !rst_exc_start) |=> (emu_mode && pst == 4'hD)); // R4

  AST_RET_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (rte_done && !rte_fs1 && !exc_start && !rst_exc_start) |=> (!emu_mode && pst == 4'h0)); // R5

  AST_INHIBIT_DROPS: assert property (@(posedge clk) disable iff (rst)
    ((bkpt_inhibit || rte_done) && bkpt_req) |=> !bkpt_fire); // R6

  AST_FORCE_AT_START: assert property (@(posedge clk) disable iff (rst)
    rst_exc_start |=> (emu_mode == $past(force_emu))); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst_exc_start && !exc_start && !rte_done) |=> $stable(emu_mode)); // R11

  AST_PRIO_EXC_OVER_RET: assert property (@(posedge clk) disable iff (rst)
    (exc_start && rte_done && !rst_exc_start && !bkpt_inhibit) |=> !bkpt_inhibit); // R10
endmodule

bind emu_mode_ctrl emu_mode_ctrl_chk #(.WORD_W(WORD_W), .FS1_POS(FS1_POS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .exc_start     (exc_start),
  .exc_is_debug  (exc_is_debug),
  .rte_done      (rte_done),
  .rte_fs1       (rte_fs1),
  .rst_exc_start (rst_exc_start),
  .force_emu     (force_emu),
  .bkpt_req      (bkpt_req),
  .emu_mode      (emu_mode),
  .frame_word    (frame_word),
  .frame_we      (frame_we),
  .pst           (pst),
  .bkpt_inhibit  (bkpt_inhibit),
  .bkpt_fire     (bkpt_fire)
);

// File: tb/emu_mode_ctrl_tb.sv
module emu_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_start = 0, exc_is_debug = 0, rte_done = 0, rte_fs1 = 0;
  logic rst_exc_start = 0, force_emu = 0, instr_done = 0, bkpt_req = 0;
  logic        emu_mode, frame_we, bkpt_inhibit, bkpt_fire;
  logic [31:0] frame_word;
  logic [3:0]  pst;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  emu_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .exc_start(exc_start), .exc_is_debug(exc_is_debug),
    .rte_done(rte_done), .rte_fs1(rte_fs1), .rst_exc_start(rst_exc_start),
    .force_emu(force_emu), .instr_done(instr_done), .bkpt_req(bkpt_req),
    .emu_mode(emu_mode), .frame_word(frame_word), .frame_we(frame_we),
    .pst(pst), .bkpt_inhibit(bkpt_inhibit), .bkpt_fire(bkpt_fire)
  );

  // behavioural reference
  bit          m_emu, m_we, m_inh, m_fire;
  bit [31:0]   m_fw;
  bit [3:0]    m_pst;

  always @(posedge clk) begin
    if (rst) begin
      m_emu <= 0; m_we <= 0; m_inh <= 0; m_fire <= 0; m_fw <= 0; m_pst <= 0;
    end else begin
      m_we   <= 0;
      m_pst  <= 0;
      m_fire <= bkpt_req && !rte_done && !m_inh;
      if (rst_exc_start) begin
        m_emu <= force_emu;
        if (instr_done) m_inh <= 0;
      end else if (exc_start) begin
        m_we <= 1;
        m_fw <= m_emu ? 32'h0002_0000 : 32'h0;
        m_emu <= exc_is_debug;
        if (exc_is_debug) m_pst <= 4'hD;
        if (instr_done) m_inh <= 0;
      end else if (rte_done) begin
        m_emu <= rte_fs1;
        m_pst <= rte_fs1 ? 4'hD : 4'h0;
        m_inh <= 1;
      end else if (instr_done) begin
        m_inh <= 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(cur_req, "model emu_mode", {31'b0, emu_mode}, {31'b0, m_emu});
    chk(cur_req, "model pst", {28'b0, pst}, {28'b0, m_pst});
    chk(cur_req, "model frame_we", {31'b0, frame_we}, {31'b0, m_we});
    chk(cur_req, "model frame_word", frame_word, m_fw);
    chk(cur_req, "model bkpt_inhibit", {31'b0, bkpt_inhibit}, {31'b0, m_inh});
    chk(cur_req, "model bkpt_fire", {31'b0, bkpt_fire}, {31'b0, m_fire});
  endtask

  task automatic idle();
    exc_start = 0; rte_done = 0; rst_exc_start = 0; instr_done = 0; bkpt_req = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    @(negedge clk); @(negedge clk);
    chk("R1", "emu in reset", {31'b0, emu_mode}, 0);
    rst = 0;
    cyc();
    chk("R1", "emu after reset", {31'b0, emu_mode}, 0);
    chk("R1", "pst after reset", {28'b0, pst}, 0);
    chk("R1", "inhibit after reset", {31'b0, bkpt_inhibit}, 0);
    chk("R1", "frame_word after reset", frame_word, 0);

    // R8 force bit ignored outside reset start
    cur_req = "R8";
    force_emu = 1; cyc(); cyc();
    chk("R8", "force ignored", {31'b0, emu_mode}, 0);
    force_emu = 0;

    // R2 debug entry
    cur_req = "R2";
    exc_start = 1; exc_is_debug = 1; cyc(); idle();
    chk("R2", "emu after debug entry", {31'b0, emu_mode}, 1);
    chk("R2", "pst on debug entry", {28'b0, pst}, 4'hD);
    cyc();
    chk("R2", "pst one cycle only", {28'b0, pst}, 0);
    chk("R11", "emu holds when idle", {31'b0, emu_mode}, 1);

    // R3 / R9 nested ordinary exceptions
    cur_req = "R3";
    exc_start = 1; exc_is_debug = 0; cyc(); idle();
    chk("R3", "frame word saved bit set", frame_word, 32'h0002_0000);
    chk("R3", "frame_we pulse", {31'b0, frame_we}, 1);
    chk("R3", "emu cleared", {31'b0, emu_mode}, 0);
    cur_req = "R9";
    exc_start = 1; cyc(); idle();
    chk("R9", "nested frame saved bit clear", frame_word, 32'h0);

    // R5 inner return, R6 inhibit window
    cur_req = "R5";
    rte_done = 1; rte_fs1 = 0; bkpt_req = 1; cyc(); idle();
    chk("R5", "emu stays clear", {31'b0, emu_mode}, 0);
    chk("R5", "pst normal", {28'b0, pst}, 0);
    chk("R6", "inhibit up after return", {31'b0, bkpt_inhibit}, 1);
    chk("R6", "request on return cycle dropped", {31'b0, bkpt_fire}, 0);
    cur_req = "R6";
    bkpt_req = 1; cyc(); cyc(); idle();
    chk("R6", "request in window dropped", {31'b0, bkpt_fire}, 0);
    cyc();
    chk("R6", "dropped request not queued", {31'b0, bkpt_fire}, 0);
    instr_done = 1; cyc(); idle();
    chk("R6", "inhibit down after instruction", {31'b0, bkpt_inhibit}, 0);
    bkpt_req = 1; cyc(); idle();
    chk("R6", "request passes after window", {31'b0, bkpt_fire}, 1);
    cyc();
    chk("R6", "fire is one cycle", {31'b0, bkpt_fire}, 0);

    // R4 outer return restores emulator mode
    cur_req = "R4";
    rte_done = 1; rte_fs1 = 1; cyc(); idle();
    chk("R9", "outer return restores mode", {31'b0, emu_mode}, 1);
    chk("R4", "pst debug on reentry", {28'b0, pst}, 4'hD);
    instr_done = 1; cyc(); idle();

    // R10 priorities
    cur_req = "R10";
    exc_start = 1; exc_is_debug = 0; rte_done = 1; rte_fs1 = 1; cyc(); idle();
    chk("R10", "exception wins over return", {31'b0, emu_mode}, 0);
    chk("R10", "losing return no inhibit", {31'b0, bkpt_inhibit}, 0);
    chk("R10", "frame written", {31'b0, frame_we}, 1);
    rst_exc_start = 1; force_emu = 1; exc_start = 1; exc_is_debug = 0; cyc(); idle();
    chk("R10", "reset start wins over exception", {31'b0, emu_mode}, 1);
    chk("R10", "no frame when reset start wins", {31'b0, frame_we}, 0);

    // R7 force bit sampled at reset exception start
    cur_req = "R7";
    rst = 1; cyc(); rst = 0; force_emu = 1; cyc();
    rst_exc_start = 1; cyc(); idle();
    chk("R7", "forced into emulator mode", {31'b0, emu_mode}, 1);
    force_emu = 0; cyc();
    chk("R8", "clearing force later ignored", {31'b0, emu_mode}, 1);
    rst_exc_start = 1; cyc(); idle();
    chk("R7", "no force gives normal mode", {31'b0, emu_mode}, 0);
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule